// File: doc/BRIEF.md
# Eight-Slot Register Bank with Hardware Set/Clear

This block holds eight registers, each of its own parameterised width, behind one shared bidirectional data bus. A bus master selects the bank, chooses a slot with a 3-bit address and either writes the bus value into that slot on a rising clock edge or reads a value back onto the bus. Every register drives its contents continuously onto a dedicated output slice, so surrounding logic can use it as a control or flag word.

Hardware next to the bank can force any register to all ones or all zeros through per-slot set and clear lines, without a bus cycle. This lets a start flag be raised by software and dropped by the engine it starts. A read does not return the stored value directly. It returns a separate per-slot read-back input. A wrapper may loop that input back from the outputs, or feed in live status instead.

The eight register outputs are packed into one flat vector, slot 0 in the least significant bits, each slot taking exactly its configured width. The read-back inputs are packed the same way.

Top module: `regbank8`

## Requirements
- R1: An active-high asynchronous reset forces every register to zero at once, without waiting for a clock edge.
- R2: When select and write enable are both high at a rising clock edge, the addressed register loads the bus value. No other register is loaded by the bus in that cycle.
- R3: A register that is not addressed, or any register while select or write enable is low, keeps its value unless its own set or clear line is high.
- R4: While select is high and write enable is low, the bank drives the bus with the addressed slot's read-back input, zero-extended to the bus width.
- R5: Whenever select is low or write enable is high, the bank leaves the bus at high impedance.
- R6: A high bit n of the set vector loads all ones into register n on the next rising edge.
- R7: A high bit n of the clear vector loads zero into register n on the next rising edge, and wins when set bit n is also high.
- R8: Set and clear on a register override a bus write addressed to that register in the same cycle.
- R9: Set and clear act whatever the state of select, write enable and address.
- R10: On a write, only the low bits that fit the register's width are stored. Bus bits above that width have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| clr_vec | input | 8 | Per-slot synchronous clear, bit n for slot n |
| set_vec | input | 8 | Per-slot synchronous set, bit n for slot n |
| sel | input | 1 | Bank select |
| wen | input | 1 | Write enable (high = write, low = read) |
| addr | input | 3 | Slot address |
| dbus | inout | BUS_W | Shared bidirectional data bus |
| rb_in | input | sum of slot widths | Packed read-back inputs, slot 0 lowest |
| rb_out | output | sum of slot widths | Packed register contents, slot 0 lowest |

## Verification
The assertions watch the storage rules in every cycle for every slot: clear yields zero, set without clear yields ones, a bus write lands exactly, and an idle slot holds. They also check that at most one slot is write-targeted at a time. The bench scenarios show what those properties cannot: zero-extension of narrow read-back values, truncation of wide bus words into narrow slots, and release of the bus. They also show the asynchronous reset taking effect between clock edges. Random select, address, data and sparse set/clear traffic is run against a bench model over a mix of deliberately unequal slot widths.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int NREG   = 8;
  localparam int ADDR_W = 3;

  typedef int width_arr_t [NREG];

  // Bit offset of slot idx in a packed vector (idx == NREG gives total width)
  function automatic int slot_offset(width_arr_t w, int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < NREG; k++) begin
      if (k < idx) acc += w[k];
    end
    return acc;
  endfunction

  function automatic int min_int(int a, int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/regbank_cell.sv
module regbank_cell #(
  parameter int W     = 8,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] wr_bus,
  output logic [W-1:0]     q
);
  localparam int CW = (W < BUS_W) ? W : BUS_W;

  logic [W-1:0] wval;

  // Keep only the bus bits that fit the slot; zero-fill if the slot is wider
  assign wval = W'(wr_bus[CW-1:0]);

  // Priority: clear, then set, then bus write
  always_ff @(posedge clk or posedge rst) begin
    if (rst)        q <= '0;
    else if (clr_i) q <= '0;
    else if (set_i) q <= '1;
    else if (wr_i)  q <= wval;
  end

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (q == '0));

  p_set_ones_r6: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> (q == '1));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !set_i && !clr_i) |=> (q == $past(wval)));

  p_idle_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !set_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
  import regbank_pkg::*;
#(
  parameter width_arr_t WID   = '{default: 8},
  parameter int         BUS_W = 16,
  parameter int         TOT_W = 64
) (
  input  logic [TOT_W-1:0]  rb_in,
  input  logic [ADDR_W-1:0] addr,
  output logic [BUS_W-1:0]  rdata
);
  logic [BUS_W-1:0] lane [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_lane
    localparam int OFF = slot_offset(WID, i);
    localparam int CW  = min_int(WID[i], BUS_W);
    assign lane[i] = BUS_W'(rb_in[OFF+CW-1:OFF]);
  end

  assign rdata = lane[addr];
endmodule

// File: rtl/regbank8.sv
module regbank8
  import regbank_pkg::*;
#(
  parameter int R0_W  = 8,
  parameter int R1_W  = 8,
  parameter int R2_W  = 8,
  parameter int R3_W  = 8,
  parameter int R4_W  = 8,
  parameter int R5_W  = 8,
  parameter int R6_W  = 8,
  parameter int R7_W  = 8,
  parameter int BUS_W = 16,
  localparam width_arr_t WID = '{R0_W, R1_W, R2_W, R3_W, R4_W, R5_W, R6_W, R7_W},
  localparam int TOT_W = slot_offset(WID, NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   clr_vec,
  input  logic [NREG-1:0]   set_vec,
  input  logic              sel,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [BUS_W-1:0]  dbus,
  input  logic [TOT_W-1:0]  rb_in,
  output logic [TOT_W-1:0]  rb_out
);
  logic [NREG-1:0]  wr_hit;
  logic [BUS_W-1:0] rdata;
  logic             rd_oe;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam int OFF = slot_offset(WID, i);

    assign wr_hit[i] = sel && wen && (addr == ADDR_W'(i));

    regbank_cell #(
      .W     (WID[i]),
      .BUS_W (BUS_W)
    ) u_cell (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (clr_vec[i]),
      .set_i  (set_vec[i]),
      .wr_i   (wr_hit[i]),
      .wr_bus (dbus),
      .q      (rb_out[OFF+WID[i]-1:OFF])
    );
  end

  regbank_rdmux #(
    .WID   (WID),
    .BUS_W (BUS_W),
    .TOT_W (TOT_W)
  ) u_rdmux (
    .rb_in (rb_in),
    .addr  (addr),
    .rdata (rdata)
  );

  assign rd_oe = sel && !wen;
  assign dbus  = rd_oe ? rdata : {BUS_W{1'bz}};

  p_single_target_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit));
endmodule

// File: tb/regbank8_bench.sv
`timescale 1ns/1ps
module regbank8_bench;
  localparam int NR = 8;
  localparam int BW = 16;
  localparam int W0 = 1, W1 = 4, W2 = 8, W3 = 16, W4 = 3, W5 = 12, W6 = 8, W7 = 5;
  localparam int TW = W0 + W1 + W2 + W3 + W4 + W5 + W6 + W7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] clr_v = '0, set_v = '0;
  logic sel = 1'b0, wen = 1'b0;
  logic [2:0] addr = '0;
  logic drv_en = 1'b0;
  logic [BW-1:0] drv_data = '0;
  logic loop = 1'b1;
  logic [TW-1:0] ext_in = '0;
  wire  [BW-1:0] bus;
  wire  [TW-1:0] rb_out;
  wire  [TW-1:0] rb_in;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [BW-1:0] mdl [NR];

  always #2.5 clk = ~clk;

  pullup pu[BW-1:0] (bus);
  assign bus   = drv_en ? drv_data : {BW{1'bz}};
  assign rb_in = loop ? rb_out : ext_in;

  regbank8 #(.R0_W(W0), .R1_W(W1), .R2_W(W2), .R3_W(W3), .R4_W(W4),
             .R5_W(W5), .R6_W(W6), .R7_W(W7), .BUS_W(BW)) u_regbank8 (
    .clk(clk), .rst(rst), .clr_vec(clr_v), .set_vec(set_v), .sel(sel),
    .wen(wen), .addr(addr), .dbus(bus), .rb_in(rb_in), .rb_out(rb_out));

  function automatic int wd(int i);
    int t[NR] = '{W0, W1, W2, W3, W4, W5, W6, W7};
    return t[i];
  endfunction
  function automatic int off(int i);
    int s = 0;
    for (int k = 0; k < i; k++) s += wd(k);
    return s;
  endfunction
  function automatic logic [BW-1:0] msk(int i);
    return BW'((32'd1 << wd(i)) - 1);
  endfunction
  function automatic logic [BW-1:0] slot(logic [TW-1:0] v, int i);
    return BW'(v >> off(i)) & msk(i);
  endfunction

  task automatic chk(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_outs(string tag);
    for (int i = 0; i < NR; i++) chk(tag, slot(rb_out, i), mdl[i]);
  endtask

  // Expected bus value from the current inputs (R4 read, R5 release)
  function automatic logic [BW-1:0] bus_exp();
    if (sel && !wen) return loop ? mdl[addr] : slot(ext_in, int'(addr));
    if (drv_en) return drv_data;
    return '1;
  endfunction

  // Drive one cycle, check the bus before the edge and outputs after it
  task automatic apply(logic s, logic w, logic [2:0] a, logic [BW-1:0] d,
                       logic [7:0] st, logic [7:0] cl, string tag);
    sel = s; wen = w; addr = a; drv_data = d; drv_en = s && w;
    set_v = st; clr_v = cl;
    #1;
    chk((s && !w) ? "R4" : "R5", bus, bus_exp());
    for (int i = 0; i < NR; i++) begin
      if (cl[i])                     mdl[i] = '0;
      else if (st[i])                mdl[i] = msk(i);
      else if (s && w && a == 3'(i)) mdl[i] = d & msk(i);
    end
    @(posedge clk); #1;
    chk_outs(tag);
    sel = 1'b0; wen = 1'b0; drv_en = 1'b0; set_v = '0; clr_v = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1; chk_outs("R1"); chk("R5", bus, 16'hFFFF);
    rst = 1'b0;
    @(posedge clk); #1;

    // R10: wide bus word into a 4-bit slot, read back zero-extended (R4)
    apply(1, 1, 3'd1, 16'hABCD, '0, '0, "R2");
    chk("R10", slot(rb_out, 1), 16'h000D);
    apply(1, 0, 3'd1, 16'h0, '0, '0, "R3");
    // full-width slot
    apply(1, 1, 3'd3, 16'hBEEF, '0, '0, "R2");
    chk("R2", slot(rb_out, 3), 16'hBEEF);
    // R3: write with select low changes nothing
    apply(0, 1, 3'd3, 16'h1234, '0, '0, "R3");
    chk("R3", slot(rb_out, 3), 16'hBEEF);
    // R6 and R9: set with bank unselected
    apply(0, 0, 3'd0, 16'h0, 8'b0000_0100, '0, "R9");
    chk("R6", slot(rb_out, 2), 16'h00FF);
    // R7: clear beats set
    apply(0, 0, 3'd0, 16'h0, 8'b0000_0100, 8'b0000_0100, "R7");
    chk("R7", slot(rb_out, 2), 16'h0000);
    // R8: set beats same-cycle write, clear beats same-cycle write
    apply(1, 1, 3'd5, 16'h0123, 8'b0010_0000, '0, "R8");
    chk("R8", slot(rb_out, 5), 16'h0FFF);
    apply(1, 1, 3'd3, 16'h5555, '0, 8'b0000_1000, "R8");
    chk("R8", slot(rb_out, 3), 16'h0000);
    // R4: read returns the external read-back input, not the stored value
    loop = 1'b0;
    ext_in = {TW{1'b1}};
    apply(1, 0, 3'd4, 16'h0, '0, '0, "R4");
    sel = 1'b1; wen = 1'b0; addr = 3'd4; #1;
    chk("R4", bus, 16'h0007);
    sel = 1'b0; #1;
    chk("R5", bus, 16'hFFFF);
    loop = 1'b1;

    // Random traffic
    for (int n = 0; n < 600; n++) begin
      logic [7:0] st, cl;
      st = '0; cl = '0;
      for (int b = 0; b < NR; b++) begin
        st[b] = ($urandom % 10) == 0;
        cl[b] = ($urandom % 12) == 0;
      end
      loop = ($urandom % 4) != 0;
      ext_in = {$urandom, $urandom};
      apply(1'($urandom), 1'($urandom), 3'($urandom), 16'($urandom), st, cl, "R2");
    end

    // R1: asynchronous reset between edges
    apply(1, 1, 3'd6, 16'h00A5, 8'h81, '0, "R2");
    #1 rst = 1'b1;
    #0.5;
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    chk_outs("R1");
    @(posedge clk); #1 rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule